// File: doc/BRIEF.md
# I2C Output Port Expander Slave

This block is an I2C slave that owns an eight-bit output register and drives it onto an eight-bit push-pull port. Each data byte a master writes replaces all eight outputs at once. Each byte a master reads carries the levels actually seen on the port pins, not the register contents. There is no register pointer and no command byte: the direction bit after the address alone selects what happens.

The bus lines are oversampled on the system clock. Each line passes through a two-flop synchronizer and then a level filter that accepts a new level only after it has held for a set number of clocks. Filtered edges then feed START/STOP detection and a bit-level protocol engine. The engine drives SDA through an open-drain pull-low enable. The low four bits of the slave address come from a strap input, and the upper three are fixed. A power-on reset loads the output register from a default-value input. A separate active-low interface reset abandons any transfer and leaves the outputs alone.

Top module: `pxp_expander`

## Requirements
- R1: The slave answers only to the 7-bit address whose bits [6:4] are 3'b101 and whose bits [3:0] equal `addr_sel` (0x50 to 0x5F). On a match it pulls SDA low during the ninth SCL pulse. On any other address it leaves SDA released and ignores the bus until the next START.
- R2: The eighth bit after START is the direction bit: 0 starts a write, 1 starts a read.
- R3: In a write, every data byte is acknowledged and loaded whole into `port_q`. The first bit on the bus lands in `port_q[7]`. This repeats for each further byte until STOP.
- R4: In a read, `pins_in` is sampled while SCL is high in the address acknowledge. That byte is sent MSB first, so `pins_in[7]` is the first bit.
- R5: When the master acknowledges a read byte, `pins_in` is sampled again during that acknowledge and sent as the next byte. When the master does not acknowledge, SDA stays released and further clocks are ignored until START.
- R6: Read data is taken from `pins_in`, never from `port_q`. A pin held to another level reads back as that level.
- R7: Holding `bus_rst_n` low abandons the transfer in progress, releases SDA and returns the interface to idle. `port_q` is unchanged. Bits clocked after release get no acknowledge until a new START.
- R8: `rst` loads `pwrup_val` into `port_q`. `bus_rst_n` never does.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After STOP, clocked bytes are ignored until START.
- R10: After synchronization, a pulse on SCL or SDA shorter than `FILT_CYC` system clocks has no effect on the protocol.
- R11: A START during a transfer (repeated START) restarts address reception directly, without a STOP.
- R12: `sda_drive_low` is asserted only while the filtered SCL is low, and it does not change while SCL is high within a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_rst_n | input | 1 | Active-low interface reset, asynchronous to clk |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_sel | input | 4 | Variable low four address bits |
| pwrup_val | input | 8 | Output value loaded on power-on reset |
| pins_in | input | 8 | Actual levels seen on the port pins |
| port_q | output | 8 | Output register driving the port |

## Verification
The bench targets the snapshot timing of reads. It changes `pins_in` just after an acknowledge, so a design that samples late, or that sends `port_q` instead of the pins, returns the wrong byte. It drops an interface reset into the middle of a data byte. A design that let this reach the output register, or that kept counting bits, would show a changed port or a spurious acknowledge. It also injects a two-clock SCL spike inside a byte, a repeated START from a write into a read, and bytes clocked after a STOP or a mismatched address. A weak filter, a missed restart or a slave that never went idle would each misplace a bit or acknowledge a byte it should ignore.

// File: rtl/pxp_pkg.sv
`timescale 1ns/1ps
package pxp_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;
    localparam logic [2:0] ADDR_FIXED = 3'b101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BIT,
        ST_WR_ACK,
        ST_RD_BIT,
        ST_RD_ACK
    } px_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                      input logic [SEL_W-1:0]  sel);
        return frame[BYTE_W-1:1] == {ADDR_FIXED, sel};
    endfunction

endpackage

// File: rtl/pxp_deglitch.sv
`timescale 1ns/1ps
module pxp_deglitch #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_CYC    = 4,
    parameter logic RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_sync,
    output logic d_flt
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

    logic [SYNC_STAGES-1:0] sh;
    logic [CW-1:0]          cnt;

    always_ff @(posedge clk) begin
        if (rst) sh <= {SYNC_STAGES{RST_VAL}};
        else     sh <= {sh[SYNC_STAGES-2:0], d_in};
    end

    assign d_sync = sh[SYNC_STAGES-1];

    // New level is accepted only after FILT_CYC consecutive disagreeing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            d_flt <= RST_VAL;
        end else if (d_sync == d_flt) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt   <= '0;
            d_flt <= d_sync;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pxp_busev.sv
`timescale 1ns/1ps
module pxp_busev
    import pxp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f & scl_d &  sda_d & ~sda_f;
        ev.stop  = scl_f & scl_d & ~sda_d &  sda_f;
        ev.rise  = scl_f & ~scl_d;
        ev.fall  = ~scl_f & scl_d;
        ev.sda   = sda_f;
    end
endmodule

// File: rtl/pxp_engine.sv
`timescale 1ns/1ps
module pxp_engine
    import pxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ifr_n,
    input  bus_ev_t           ev,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic [BYTE_W-1:0] pwrup_val,
    input  logic [BYTE_W-1:0] pins_in,
    output logic [BYTE_W-1:0] port_q,
    output logic              sda_drive_low,
    output px_state_e         st
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rd_dir;
    logic              m_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            bitcnt        <= '0;
            rx_sh         <= '0;
            tx_sh         <= '0;
            rd_dir        <= 1'b0;
            m_ack         <= 1'b0;
            sda_drive_low <= 1'b0;
            port_q        <= pwrup_val;
        end else if (!ifr_n) begin
            st            <= ST_IDLE;
            bitcnt        <= '0;
            sda_drive_low <= 1'b0;
        end else if (ev.stop) begin
            st            <= ST_IDLE;
            sda_drive_low <= 1'b0;
        end else if (ev.start) begin
            st            <= ST_ADDR;
            bitcnt        <= '0;
            sda_drive_low <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (ev.rise) begin
                        rx_sh  <= {rx_sh[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.fall && bitcnt == LAST_BIT) begin
                        if (addr_hit(rx_sh, addr_sel)) begin
                            st            <= ST_ADDR_ACK;
                            rd_dir        <= rx_sh[0];
                            sda_drive_low <= 1'b1;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.rise && rd_dir) begin
                        tx_sh <= pins_in;
                    end else if (ev.fall) begin
                        bitcnt <= '0;
                        if (rd_dir) begin
                            st            <= ST_RD_BIT;
                            sda_drive_low <= ~tx_sh[BYTE_W-1];
                        end else begin
                            st            <= ST_WR_BIT;
                            sda_drive_low <= 1'b0;
                        end
                    end
                end
                ST_WR_BIT: begin
                    if (ev.rise) begin
                        rx_sh  <= {rx_sh[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.fall && bitcnt == LAST_BIT) begin
                        port_q        <= rx_sh;
                        sda_drive_low <= 1'b1;
                        st            <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (ev.fall) begin
                        sda_drive_low <= 1'b0;
                        bitcnt        <= '0;
                        st            <= ST_WR_BIT;
                    end
                end
                ST_RD_BIT: begin
                    if (ev.rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.fall) begin
                        if (bitcnt == LAST_BIT) begin
                            sda_drive_low <= 1'b0;
                            st            <= ST_RD_ACK;
                        end else begin
                            tx_sh         <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_drive_low <= ~tx_sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.rise) begin
                        m_ack <= ~ev.sda;
                        if (!ev.sda) tx_sh <= pins_in;
                    end else if (ev.fall) begin
                        if (m_ack) begin
                            st            <= ST_RD_BIT;
                            bitcnt        <= '0;
                            sda_drive_low <= ~tx_sh[BYTE_W-1];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pxp_expander.sv
`timescale 1ns/1ps
module pxp_expander
    import pxp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic [BYTE_W-1:0] pwrup_val,
    input  logic [BYTE_W-1:0] pins_in,
    output logic [BYTE_W-1:0] port_q
);
    localparam int N_LINES = 2;
    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [N_LINES-1:0] raw_v;
    logic [N_LINES-1:0] sync_v;
    logic [N_LINES-1:0] flt_v;
    logic [SYNC_STAGES-1:0] ifr_sh;
    logic      ifr_n;
    bus_ev_t   bus_ev;
    px_state_e st;

    assign raw_v = {scl_in, sda_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        pxp_deglitch #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYC    (FILT_CYC),
            .RST_VAL     (1'b1)
        ) u_flt (
            .clk    (clk),
            .rst    (rst),
            .d_in   (raw_v[g]),
            .d_sync (sync_v[g]),
            .d_flt  (flt_v[g])
        );
    end

    // Interface reset is brought into the clock domain before use
    always_ff @(posedge clk) begin
        if (rst) ifr_sh <= '0;
        else     ifr_sh <= {ifr_sh[SYNC_STAGES-2:0], bus_rst_n};
    end
    assign ifr_n = ifr_sh[SYNC_STAGES-1];

    pxp_busev u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_f (flt_v[IDX_SCL]),
        .sda_f (flt_v[IDX_SDA]),
        .ev    (bus_ev)
    );

    pxp_engine u_eng (
        .clk           (clk),
        .rst           (rst),
        .ifr_n         (ifr_n),
        .ev            (bus_ev),
        .addr_sel      (addr_sel),
        .pwrup_val     (pwrup_val),
        .pins_in       (pins_in),
        .port_q        (port_q),
        .sda_drive_low (sda_drive_low),
        .st            (st)
    );
endmodule

// File: rtl/pxp_chk.sv
`timescale 1ns/1ps
module pxp_chk
    import pxp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ifr_n,
    input logic [1:0]        sync_v,
    input logic [1:0]        flt_v,
    input logic              sda_drive_low,
    input logic [BYTE_W-1:0] port_q,
    input logic              ev_start,
    input logic              ev_stop,
    input px_state_e         st
);
    // R7
    ifr_release_chk: assert property (@(posedge clk) disable iff (rst)
        !ifr_n |=> !sda_drive_low);

    // R3
    port_update_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_q) |-> !flt_v[1]);

    // R12
    drive_on_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !flt_v[1]);

    // R11
    start_to_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_start && ifr_n) |=> st == ST_ADDR);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (!sda_drive_low && st == ST_IDLE));

    // R10
    scl_filter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(flt_v[1]) |-> ($past(sync_v[1], 2) == flt_v[1]));

    // R10
    sda_filter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(flt_v[0]) |-> ($past(sync_v[0], 2) == flt_v[0]));
endmodule

bind pxp_expander pxp_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ifr_n         (ifr_n),
    .sync_v        (sync_v),
    .flt_v         (flt_v),
    .sda_drive_low (sda_drive_low),
    .port_q        (port_q),
    .ev_start      (bus_ev.start),
    .ev_stop       (bus_ev.stop),
    .st            (st)
);

// File: tb/pxp_expander_tb.sv
`timescale 1ns/1ps
module pxp_expander_tb;
    localparam int Q = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, bus_rst_n, scl_m, sda_m;
    logic [3:0] addr_sel;
    logic [7:0] pwrup, pins, port_q;
    logic       sda_drive_low, sda_line;

    assign sda_line = sda_m & ~sda_drive_low;

    pxp_expander u_dut (
        .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n),
        .scl_in(scl_m), .sda_in(sda_line), .sda_drive_low(sda_drive_low),
        .addr_sel(addr_sel), .pwrup_val(pwrup), .pins_in(pins), .port_q(port_q)
    );

    int   n_chk = 0, n_fail = 0;
    logic [7:0] exp_port;
    bit   track = 0, settle = 0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Reference model: output register compared on every clock (R3, R7, R8)
    always @(negedge clk) begin
        if (track && !settle) chk("R3/R7 port model", port_q, exp_port);
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bitx(input logic b, output logic s);
        logic s2;
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        s = sda_line; wq();
        s2 = sda_line;
        chk("R12 sda stable in high", {7'd0, s2}, {7'd0, s});
        scl_m = 1'b0; wq();
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, input bit loads, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) settle = 1;
            bitx(d[i], s);
        end
        if (loads) exp_port = d;
        settle = 0;
        bitx(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bitx(1'b1, s);
            d[i] = s;
        end
        bitx(~mack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic ack, s;
        logic [7:0] d;
        rst = 1; bus_rst_n = 1; scl_m = 1; sda_m = 1;
        addr_sel = 4'hA; pwrup = 8'hC3; pins = 8'h00;
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
        // R8 power-on default
        chk("R8 reset port", port_q, 8'hC3);
        chk("R12 reset drive", {7'd0, sda_drive_low}, 8'd0);
        exp_port = 8'hC3; track = 1;

        // R1 R2 R3 single write
        start_c();
        send_byte({7'h5A, 1'b0}, 0, ack); chk("R1 addr ack", {7'd0, ack}, 8'd1);
        send_byte(8'h3C, 1, ack); chk("R3 data ack", {7'd0, ack}, 8'd1);
        chk("R3 port after write", port_q, 8'h3C);
        stop_c();

        // R3 multi-byte write
        start_c();
        send_byte({7'h5A, 1'b0}, 0, ack);
        send_byte(8'h81, 1, ack); chk("R3 byte1 ack", {7'd0, ack}, 8'd1);
        chk("R3 byte1 port", port_q, 8'h81);
        send_byte(8'h7E, 1, ack); chk("R3 byte2 port", port_q, 8'h7E);
        send_byte(8'h05, 1, ack); chk("R3 byte3 ack", {7'd0, ack}, 8'd1);
        stop_c();

        // R1 mismatched low and high address bits
        start_c();
        send_byte({7'h5B, 1'b0}, 0, ack); chk("R1 low bits nack", {7'd0, ack}, 8'd0);
        send_byte(8'hFF, 0, ack); chk("R1 ignored data nack", {7'd0, ack}, 8'd0);
        stop_c();
        start_c();
        send_byte({7'h6A, 1'b0}, 0, ack); chk("R1 fixed bits nack", {7'd0, ack}, 8'd0);
        stop_c();
        chk("R1 port unchanged", port_q, 8'h05);

        // R4 R5 R6 read with snapshots
        pins = 8'hA5;
        start_c();
        send_byte({7'h5A, 1'b1}, 0, ack); chk("R2 read addr ack", {7'd0, ack}, 8'd1);
        pins = 8'h12;
        recv_byte(1, d); chk("R4 R6 first byte", d, 8'hA5);
        pins = 8'h99;
        recv_byte(0, d); chk("R5 resampled byte", d, 8'h12);
        bitx(1'b1, s); chk("R5 released after nack", {7'd0, s}, 8'd1);
        stop_c();

        // R11 repeated start from write to read
        start_c();
        send_byte({7'h5A, 1'b0}, 0, ack);
        send_byte(8'h6B, 1, ack);
        pins = 8'hF0;
        start_c();
        send_byte({7'h5A, 1'b1}, 0, ack); chk("R11 restart ack", {7'd0, ack}, 8'd1);
        recv_byte(0, d); chk("R11 R6 read pins", d, 8'hF0);
        stop_c();

        // R7 interface reset mid byte
        start_c();
        send_byte({7'h5A, 1'b0}, 0, ack);
        for (int i = 0; i < 4; i++) bitx(1'b0, s);
        bus_rst_n = 0;
        repeat (10) @(negedge clk);
        chk("R7 drive released", {7'd0, sda_drive_low}, 8'd0);
        chk("R7 R8 port kept", port_q, 8'h6B);
        bus_rst_n = 1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 4; i++) bitx(1'b0, s);
        bitx(1'b1, s); chk("R7 no ack after reset", {7'd0, s}, 8'd1);
        stop_c();
        start_c();
        send_byte({7'h5A, 1'b0}, 0, ack); chk("R7 recovers", {7'd0, ack}, 8'd1);
        send_byte(8'h99, 1, ack);
        // R9 bytes after stop are ignored
        stop_c();
        scl_m = 1'b0; wq();
        send_byte({7'h5A, 1'b0}, 0, ack); chk("R9 no ack after stop", {7'd0, ack}, 8'd0);
        send_byte(8'h00, 0, ack);
        stop_c();

        // R10 short SCL spike inside a data byte
        start_c();
        send_byte({7'h5A, 1'b0}, 0, ack);
        for (int i = 7; i >= 4; i--) bitx(logic'((8'h3C >> i) & 8'h01), s);
        @(negedge clk) scl_m = 1'b1;
        @(negedge clk);
        @(negedge clk) scl_m = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            if (i == 0) settle = 1;
            bitx(logic'((8'h3C >> i) & 8'h01), s);
        end
        exp_port = 8'h3C; settle = 0;
        bitx(1'b1, s); chk("R10 ack after spike", {7'd0, ~s}, 8'd1);
        chk("R10 port after spike", port_q, 8'h3C);
        stop_c();

        // R8 power-on reset reloads default
        track = 0; pwrup = 8'h0F; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        chk("R8 reload default", port_q, 8'h0F);

        summary();
        $finish;
    end
endmodule